// File: doc/BRIEF.md
# Configuration Load Sequencer

This block is a hardware sequencer that walks a programmable-logic configuration engine through one complete load. On a start strobe it reads a five-bit mode-select strap and chooses the configuration data width and the clock-to-data ratio from it. It then takes control of the configuration lines, cycles the engine's reset and waits for each phase the engine reports. It forwards a stream of 32-bit image words to the engine's data port and checks the two monitor bits. It then issues two bursts of extra configuration clocks, first to bring the engine into initialization and then into user mode, and finally gives up drive of the lines.

Every wait has its own poll limit and its own numbered failure code. On any failure the control lines return to their idle value. A done flag or an error flag with a code stays visible until the next accepted start. An abort strobe returns the sequencer to idle at any time. The configuration engine itself sits outside the block.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset `ctrl_o` is 0x002 (only the active-low enable bit 1 high), and `busy_o`, `done_o`, `err_o`, `img_ready_o`, `cfg_clk_o` and `eoi_we_o` are low, with `err_code_o` at 0.
- R2: On an accepted start the strap `status_i[7:3]` is decoded into `ctrl_o`. Strap bit 3 (`status_i[6]`) is copied to the width bit 9. The ratio field `ctrl_o[7:6]` uses the codes x1=0, x2=1, x4=2, x8=3. When the wide bit is set, strap bits 1:0 equal to 0, 1 and 2 select x1, x4 and x8. When it is clear, they select x1, x2 and x4. The value 3 selects x1.
- R3: The start sequence runs in a fixed order, one step per cycle: clear enable bit 1, set drive bit 0, set reset-pull bit 2. The sequencer then waits for phase 1 on `status_i[2:0]` and clears the pull. It waits for phase 2, gives a single `eoi_we_o` pulse with `eoi_mask_o` = 0xFFF, and in the following cycle sets data-port bit 8 together with `img_ready_o`.
- R4: Each word accepted (`img_valid_i` high while `img_ready_o` is high) appears on `data_o` with `data_we_o` high in the next cycle, in order. The word marked `img_last_i` ends the stream.
- R5: After the last word, if monitor bits `mon_i[1:0]` are both 0 the load fails with code 3. Otherwise bit 8 is cleared and the load continues.
- R6: The sequencer then gives exactly CLK_INIT pulses on `cfg_clk_o`, waits for `clk_ack_i`, and waits for phase 3 or phase 4. It gives exactly CLK_USER pulses, waits for `clk_ack_i`, and waits for phase 4. It then clears drive bit 0 and raises `done_o`. The width and ratio bits stay as decoded and bit 1 stays low.
- R7: Each phase wait gives up after TIMEOUT polls with code 1 (reset phase), 2 (configuration phase), 6 (initialization) or 8 (user).
- R8: TIMEOUT consecutive cycles in the stream without an accepted word fail the load with code 4.
- R9: A clock-burst acknowledge that does not arrive within TIMEOUT cycles fails the load with code 5 for the first burst and code 7 for the second.
- R10: A start with `img_addr_i` not zero (image not 32-bit aligned) is refused with code 9 in the next cycle. `ctrl_o` is left unchanged.
- R11: `abort_i` returns the sequencer to idle in the next cycle with `ctrl_o` at 0x002 and no further clock pulses.
- R12: On any failure of codes 1 to 8, `ctrl_o` returns to 0x002. `done_o` and `err_o` are never high together, stay unchanged until the next start in idle, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken in idle only |
| abort_i | input | 1 | Abort strobe, returns to idle |
| img_addr_i | input | 2 | Low bits of the image start address |
| status_i | input | 8 | Strap in bits 7:3, engine phase in bits 2:0 |
| mon_i | input | 2 | Engine monitor bits (status, done) |
| clk_ack_i | input | 1 | Clock-burst count-done flag from the engine |
| img_valid_i | input | 1 | Image word valid |
| img_data_i | input | 32 | Image word |
| img_last_i | input | 1 | Marks the final image word |
| img_ready_o | output | 1 | Sequencer accepts image words |
| data_o | output | 32 | Word to the engine's data port |
| data_we_o | output | 1 | Write strobe for `data_o` |
| ctrl_o | output | 10 | Control lines: width 9, data port 8, ratio 7:6, pull 2, enable (low) 1, drive 0 |
| eoi_we_o | output | 1 | Monitor interrupt-clear strobe |
| eoi_mask_o | output | 12 | Interrupt-clear mask |
| cfg_clk_o | output | 1 | Extra configuration clock pulses |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load completed |
| err_o | output | 1 | Last load failed |
| err_code_o | output | 4 | Failure code 1 to 9, 0 when none |

## Verification
The hard cases to reach are the late failures: the second-burst acknowledge timeout (code 7) and the user-phase timeout (code 8). To reach them, every earlier phase, the stream and the first burst must succeed, and exactly one later response must then be withheld. The bench models the engine as a phase machine driven by the pull, drive and clock lines. Its switches suppress one response at a time, such as the acknowledge only after the pulse count passes CLK_INIT, or the last phase step. The poll limit and burst lengths are shrunk so that each timeout lands within a few dozen cycles.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_RESET   = 3'd1,
    PH_CONFIG  = 3'd2,
    PH_INIT    = 3'd3,
    PH_USER    = 3'd4,
    PH_UNKNOWN = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_RESET   = 4'd1,
    ERR_CONFIG  = 4'd2,
    ERR_MONITOR = 4'd3,
    ERR_STREAM  = 4'd4,
    ERR_CLK_A   = 4'd5,
    ERR_INIT    = 4'd6,
    ERR_CLK_B   = 4'd7,
    ERR_USER    = 4'd8,
    ERR_ALIGN   = 4'd9
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CEN, ST_DRV, ST_PULL, ST_WRST, ST_WCFG, ST_EOI, ST_STREAM,
    ST_CHECK, ST_CLK1, ST_WCK1, ST_WINIT, ST_CLK2, ST_WCK2, ST_WUSER
  } state_e;

  localparam int CTRL_W   = 10;
  localparam int CB_DRIVE = 0;
  localparam int CB_CEN_N = 1;
  localparam int CB_PULL  = 2;
  localparam int CB_RATIO = 6;
  localparam int CB_DPEN  = 8;
  localparam int CB_WIDE  = 9;

  localparam logic [CTRL_W-1:0] CTRL_IDLE = 10'h002;
  localparam logic [11:0]       EOI_ALL   = 12'hFFF;

endpackage

// File: rtl/cfg_msel_decode.sv
module cfg_msel_decode
  import cfg_load_pkg::*;
(
  input  logic       wide_sel_i,
  input  logic [1:0] rate_sel_i,
  output logic       wide_o,
  output logic [1:0] ratio_o
);

  always_comb begin
    wide_o = wide_sel_i;
    case (rate_sel_i)
      2'd0:    ratio_o = RATIO_X1;
      2'd1:    ratio_o = wide_sel_i ? RATIO_X4 : RATIO_X2;
      2'd2:    ratio_o = wide_sel_i ? RATIO_X8 : RATIO_X4;
      default: ratio_o = RATIO_X1;
    endcase
  end

endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int LIMIT = 32'h0100_0000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (en_i && (cnt_q != CW'(LIMIT - 1))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign exp_o = en_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/cfg_clk_burst.sv
module cfg_clk_burst #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             clk_o,
  output logic             busy_o
);

  logic [CNT_W-1:0] rem_q;
  logic             hi_q;

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      rem_q <= '0;
      hi_q  <= 1'b0;
    end else if (start_i) begin
      rem_q <= count_i;
      hi_q  <= 1'b0;
    end else if (rem_q != '0) begin
      hi_q <= ~hi_q;
      if (hi_q) rem_q <= rem_q - 1'b1;
    end
  end

  assign clk_o  = hi_q;
  assign busy_o = (rem_q != '0);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int TIMEOUT  = 32'h0100_0000,
  parameter int CLK_INIT = 4,
  parameter int CLK_USER = 32'h5000,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [1:0]        img_addr_i,
  input  logic [7:0]        status_i,
  input  logic [1:0]        mon_i,
  input  logic              clk_ack_i,
  input  logic              img_valid_i,
  input  logic [DATA_W-1:0] img_data_i,
  input  logic              img_last_i,
  output logic              img_ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_we_o,
  output logic [9:0]        ctrl_o,
  output logic              eoi_we_o,
  output logic [11:0]       eoi_mask_o,
  output logic              cfg_clk_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [3:0]        err_code_o
);

  localparam int CLK_MAX = (CLK_INIT > CLK_USER) ? CLK_INIT : CLK_USER;
  localparam int CNT_W   = $clog2(CLK_MAX + 1);

  state_e             st_q, st_d;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  data_q;
  logic               data_we_q, eoi_we_q, done_q, err_q;
  logic [3:0]         code_q, code_d;
  logic               fail_d;

  logic               wide_dec;
  logic [1:0]         ratio_dec;
  logic [2:0]         phase;
  logic               accept, tmr_en, tmr_clr, tmr_exp;
  logic               bst_start, bst_busy, bst_clk;
  logic [CNT_W-1:0]   bst_count;
  logic               unused_strap;

  assign phase        = status_i[2:0];
  assign unused_strap = ^{status_i[7], status_i[5]};
  assign accept       = img_valid_i && (st_q == ST_STREAM);

  cfg_msel_decode u_dec (
    .wide_sel_i (status_i[6]),
    .rate_sel_i (status_i[4:3]),
    .wide_o     (wide_dec),
    .ratio_o    (ratio_dec)
  );

  assign tmr_en = (st_q == ST_WRST)  || (st_q == ST_WCFG)  || (st_q == ST_STREAM) ||
                  (st_q == ST_WCK1)  || (st_q == ST_WINIT) || (st_q == ST_WCK2)   ||
                  (st_q == ST_WUSER);
  assign tmr_clr = (st_d != st_q) || accept || abort_i;

  cfg_poll_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .exp_o (tmr_exp)
  );

  assign bst_start = (st_q == ST_CLK1) || (st_q == ST_CLK2);
  assign bst_count = (st_q == ST_CLK1) ? CNT_W'(CLK_INIT) : CNT_W'(CLK_USER);

  cfg_clk_burst #(.CNT_W(CNT_W)) u_bst (
    .clk     (clk),
    .rst     (rst),
    .kill_i  (abort_i || fail_d),
    .start_i (bst_start),
    .count_i (bst_count),
    .clk_o   (bst_clk),
    .busy_o  (bst_busy)
  );

  // Next-state and failure detection
  always_comb begin
    st_d   = st_q;
    fail_d = 1'b0;
    code_d = ERR_NONE;
    case (st_q)
      ST_IDLE:  if (start_i && (img_addr_i == 2'b00)) st_d = ST_CEN;
      ST_CEN:   st_d = ST_DRV;
      ST_DRV:   st_d = ST_PULL;
      ST_PULL:  st_d = ST_WRST;
      ST_WRST: begin
        if (phase == PH_RESET) st_d = ST_WCFG;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_RESET; end
      end
      ST_WCFG: begin
        if (phase == PH_CONFIG) st_d = ST_EOI;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_CONFIG; end
      end
      ST_EOI:   st_d = ST_STREAM;
      ST_STREAM: begin
        if (accept && img_last_i) st_d = ST_CHECK;
        else if (!accept && tmr_exp) begin fail_d = 1'b1; code_d = ERR_STREAM; end
      end
      ST_CHECK: begin
        if (mon_i == 2'b00) begin fail_d = 1'b1; code_d = ERR_MONITOR; end
        else st_d = ST_CLK1;
      end
      ST_CLK1:  st_d = ST_WCK1;
      ST_WCK1: begin
        if (!bst_busy && clk_ack_i) st_d = ST_WINIT;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_CLK_A; end
      end
      ST_WINIT: begin
        if ((phase == PH_INIT) || (phase == PH_USER)) st_d = ST_CLK2;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_INIT; end
      end
      ST_CLK2:  st_d = ST_WCK2;
      ST_WCK2: begin
        if (!bst_busy && clk_ack_i) st_d = ST_WUSER;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_CLK_B; end
      end
      ST_WUSER: begin
        if (phase == PH_USER) st_d = ST_IDLE;
        else if (tmr_exp) begin fail_d = 1'b1; code_d = ERR_USER; end
      end
      default:  st_d = ST_IDLE;
    endcase
    if (fail_d) st_d = ST_IDLE;
  end

  // State, control lines and result flags
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ctrl_q    <= CTRL_IDLE;
      data_q    <= '0;
      data_we_q <= 1'b0;
      eoi_we_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= ERR_NONE;
    end else if (abort_i) begin
      st_q      <= ST_IDLE;
      ctrl_q    <= CTRL_IDLE;
      data_we_q <= 1'b0;
      eoi_we_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      data_we_q <= accept;
      eoi_we_q  <= 1'b0;
      if (accept) data_q <= img_data_i;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            done_q <= 1'b0;
            if (img_addr_i != 2'b00) begin
              err_q  <= 1'b1;
              code_q <= ERR_ALIGN;
            end else begin
              err_q  <= 1'b0;
              code_q <= ERR_NONE;
              ctrl_q <= CTRL_IDLE;
              ctrl_q[CB_WIDE]         <= wide_dec;
              ctrl_q[CB_RATIO +: 2]   <= ratio_dec;
            end
          end
        end
        ST_CEN:   ctrl_q[CB_CEN_N] <= 1'b0;
        ST_DRV:   ctrl_q[CB_DRIVE] <= 1'b1;
        ST_PULL:  ctrl_q[CB_PULL]  <= 1'b1;
        ST_WRST:  if (st_d == ST_WCFG) ctrl_q[CB_PULL] <= 1'b0;
        ST_WCFG:  if (st_d == ST_EOI) eoi_we_q <= 1'b1;
        ST_EOI:   ctrl_q[CB_DPEN] <= 1'b1;
        ST_CHECK: if (st_d == ST_CLK1) ctrl_q[CB_DPEN] <= 1'b0;
        ST_WUSER: begin
          if ((st_d == ST_IDLE) && !fail_d) begin
            ctrl_q[CB_DRIVE] <= 1'b0;
            done_q           <= 1'b1;
          end
        end
        default: ;
      endcase
      if (fail_d) begin
        ctrl_q <= CTRL_IDLE;
        err_q  <= 1'b1;
        code_q <= code_d;
      end
    end
  end

  assign img_ready_o = (st_q == ST_STREAM);
  assign data_o      = data_q;
  assign data_we_o   = data_we_q;
  assign ctrl_o      = ctrl_q;
  assign eoi_we_o    = eoi_we_q;
  assign eoi_mask_o  = eoi_we_q ? EOI_ALL : 12'h000;
  assign cfg_clk_o   = bst_clk;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        abort_i,
  input logic        img_valid_i,
  input logic [31:0] img_data_i,
  input logic        img_ready_o,
  input logic [31:0] data_o,
  input logic        data_we_o,
  input logic [9:0]  ctrl_o,
  input logic        eoi_we_o,
  input logic        cfg_clk_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [3:0]  err_code_o
);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (ctrl_o == 10'h002) && !busy_o && !cfg_clk_o); // R11

  AST_READY_WITH_PORT: assert property (@(posedge clk) disable iff (rst)
    img_ready_o |-> (ctrl_o[8] && ctrl_o[0] && !ctrl_o[1] && !ctrl_o[2])); // R3

  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoi_we_o |=> !eoi_we_o); // R3

  AST_WORD_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (img_valid_i && img_ready_o && !abort_i) |=> (data_we_o && (data_o == $past(img_data_i)))); // R4

  AST_CLK_UNDER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cfg_clk_o |-> (ctrl_o[0] && !ctrl_o[8])); // R6

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ((err_code_o >= 4'd1) && (err_code_o <= 4'd9))); // R7

  AST_FAIL_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_o) && (err_code_o != 4'd9)) |-> (ctrl_o == 10'h002)); // R12

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o) && !(busy_o && (done_o || err_o))); // R12

endmodule

bind cfg_load_seq cfg_load_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .abort_i     (abort_i),
  .img_valid_i (img_valid_i),
  .img_data_i  (img_data_i),
  .img_ready_o (img_ready_o),
  .data_o      (data_o),
  .data_we_o   (data_we_o),
  .ctrl_o      (ctrl_o),
  .eoi_we_o    (eoi_we_o),
  .cfg_clk_o   (cfg_clk_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .err_code_o  (err_code_o)
);

// File: tb/cfg_load_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_load_seq_tb_top;

  localparam int TMO = 40;
  localparam int CI  = 4;
  localparam int CU  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, abort_i = 1'b0;
  logic [1:0]  img_addr_i = 2'b00;
  logic [4:0]  msel_r = 5'd0;
  logic [2:0]  phase_m = 3'd0;
  logic [7:0]  status_i;
  logic [1:0]  mon_i = 2'b11;
  logic        clk_ack_i = 1'b0;
  logic        img_valid_i = 1'b0, img_last_i = 1'b0;
  logic [31:0] img_data_i = '0;
  logic        img_ready_o, data_we_o, eoi_we_o, cfg_clk_o, busy_o, done_o, err_o;
  logic [31:0] data_o;
  logic [9:0]  ctrl_o;
  logic [11:0] eoi_mask_o;
  logic [3:0]  err_code_o;

  // engine model switches
  logic no_rst = 0, no_cfg = 0, no_init = 0, no_user = 0, no_ack = 0, no_ack2 = 0, i2u = 0;
  int   mdl_pulses = 0, gap = 0, pulse_seen = 0, cyc = 0;
  int   n_cmp = 0, n_bad = 0;

  assign status_i = {msel_r, phase_m};

  always #10 clk = ~clk;

  cfg_load_seq #(.TIMEOUT(TMO), .CLK_INIT(CI), .CLK_USER(CU)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .img_addr_i(img_addr_i),
    .status_i(status_i), .mon_i(mon_i), .clk_ack_i(clk_ack_i), .img_valid_i(img_valid_i),
    .img_data_i(img_data_i), .img_last_i(img_last_i), .img_ready_o(img_ready_o),
    .data_o(data_o), .data_we_o(data_we_o), .ctrl_o(ctrl_o), .eoi_we_o(eoi_we_o),
    .eoi_mask_o(eoi_mask_o), .cfg_clk_o(cfg_clk_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .err_code_o(err_code_o)
  );

  // Configuration engine model
  always @(posedge clk) begin
    if (cfg_clk_o) begin
      mdl_pulses <= mdl_pulses + 1;
      pulse_seen <= pulse_seen + 1;
      gap        <= 0;
      clk_ack_i  <= 1'b0;
    end else if (gap < 3) begin
      gap <= gap + 1;
    end else begin
      clk_ack_i <= !no_ack && !(no_ack2 && (mdl_pulses > CI));
    end
    if (!ctrl_o[0]) begin
      phase_m <= 3'd0; mdl_pulses <= 0;
    end else if (ctrl_o[2]) begin
      phase_m <= no_rst ? 3'd0 : 3'd1; mdl_pulses <= 0;
    end else if (phase_m == 3'd1 && !no_cfg) begin
      phase_m <= 3'd2;
    end else if (phase_m == 3'd2 && mdl_pulses >= CI && !no_init) begin
      phase_m <= i2u ? 3'd4 : 3'd3;
    end else if (phase_m == 3'd3 && mdl_pulses >= CI + CU && !no_user) begin
      phase_m <= 3'd4;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_model(input logic r, input logic c, input logic in, input logic us,
                           input logic a, input logic a2, input logic iu);
    no_rst = r; no_cfg = c; no_init = in; no_user = us; no_ack = a; no_ack2 = a2; i2u = iu;
  endtask

  task automatic kick(input logic [4:0] m, input logic [1:0] al);
    @(negedge clk);
    msel_r = m; img_addr_i = al; start_i = 1'b1; pulse_seen = 0;
    @(negedge clk);
    start_i = 1'b0; img_addr_i = 2'b00;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 600; i++) begin
      if (done_o || err_o) break;
      @(negedge clk);
    end
  endtask

  task automatic feed(input int n, input logic poke);
    for (int i = 0; i < 80 && !img_ready_o; i++) @(negedge clk);
    chk("R3 ready with data port bit", {img_ready_o, ctrl_o[8]}, 2'b11);
    for (int i = 0; i < n; i++) begin
      img_valid_i = 1'b1; img_data_i = 32'hA500_0000 + i; img_last_i = (i == n - 1);
      if (poke && i == 0) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R4 word forwarded", {31'b0, data_we_o}, 32'd1);
      chk("R4 word value", data_o, 32'hA500_0000 + i);
    end
    img_valid_i = 1'b0; img_last_i = 1'b0;
  endtask

  task automatic t_full(input logic [4:0] m, input logic [1:0] mon, input logic w,
                        input logic [1:0] r, input logic poke, input logic iu);
    logic [9:0] e;
    set_model(0, 0, 0, 0, 0, 0, iu);
    mon_i = mon;
    e = 10'h002 | (10'(w) << 9) | (10'(r) << 6);
    kick(m, 2'b00);
    chk("R2 strap decode", ctrl_o, e);
    @(negedge clk); e[1] = 1'b0; chk("R3 enable cleared first", ctrl_o, e);
    @(negedge clk); e[0] = 1'b1; chk("R3 drive set second", ctrl_o, e);
    @(negedge clk); e[2] = 1'b1; chk("R3 pull set third", ctrl_o, e);
    for (int i = 0; i < 40 && !eoi_we_o; i++) @(negedge clk);
    chk("R3 eoi pulse mask", {eoi_we_o, eoi_mask_o}, {1'b1, 12'hFFF});
    chk("R3 pull released before eoi", ctrl_o, e & ~10'h004);
    @(negedge clk);
    chk("R3 data port after eoi", {img_ready_o, ctrl_o[8]}, 2'b11);
    feed(5, poke);
    wait_end();
    chk("R6 done raised", {done_o, err_o, err_code_o}, {1'b1, 1'b0, 4'd0});
    chk("R6 final control", ctrl_o, e & ~10'h005);
    chk("R6 pulse count", pulse_seen, CI + CU);
    repeat (5) @(negedge clk);
    chk("R12 done held", {done_o, busy_o}, 2'b10);
  endtask

  task automatic t_decode(input logic [4:0] m, input logic w, input logic [1:0] r);
    kick(m, 2'b00);
    chk("R2 decode", ctrl_o, 10'h002 | (10'(w) << 9) | (10'(r) << 6));
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R11 abort to idle", {ctrl_o, busy_o}, {10'h002, 1'b0});
  endtask

  task automatic t_err(input string tag, input int words, input logic [3:0] code);
    kick(5'b00000, 2'b00);
    if (words > 0) feed(words, 1'b0);
    wait_end();
    chk(tag, {done_o, err_o, err_code_o}, {1'b0, 1'b1, code});
    chk("R12 control released on failure", ctrl_o, 10'h002);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset control", ctrl_o, 10'h002);
    chk("R1 reset flags", {busy_o, done_o, err_o, img_ready_o, cfg_clk_o, eoi_we_o, err_code_o},
        {6'b0, 4'd0});

    t_full(5'b01001, 2'b11, 1'b1, 2'd2, 1'b0, 1'b0);
    kick(5'b00000, 2'b01);
    chk("R10 misaligned refused", {busy_o, err_o, err_code_o}, {1'b0, 1'b1, 4'd9});
    chk("R10 control unchanged", ctrl_o, 10'h280);
    t_full(5'b00010, 2'b01, 1'b0, 2'd2, 1'b1, 1'b1); // R12 start while busy ignored
    t_full(5'b01010, 2'b10, 1'b1, 2'd3, 1'b0, 1'b0);

    t_decode(5'b00000, 1'b0, 2'd0);
    t_decode(5'b00001, 1'b0, 2'd1);
    t_decode(5'b00011, 1'b0, 2'd0);
    t_decode(5'b01000, 1'b1, 2'd0);
    t_decode(5'b11011, 1'b1, 2'd0);

    set_model(1, 0, 0, 0, 0, 0, 0); mon_i = 2'b11; t_err("R7 reset phase timeout", 0, 4'd1);
    set_model(0, 1, 0, 0, 0, 0, 0); t_err("R7 config phase timeout", 0, 4'd2);
    set_model(0, 0, 0, 0, 0, 0, 0); mon_i = 2'b00; t_err("R5 monitor error", 3, 4'd3);
    mon_i = 2'b11; t_err("R8 stream stall", 0, 4'd4);
    set_model(0, 0, 0, 0, 1, 0, 0); t_err("R9 first burst ack", 2, 4'd5);
    set_model(0, 0, 1, 0, 0, 0, 0); t_err("R7 init timeout", 2, 4'd6);
    set_model(0, 0, 0, 0, 0, 1, 0); t_err("R9 second burst ack", 2, 4'd7);
    set_model(0, 0, 0, 1, 0, 0, 0); t_err("R7 user timeout", 2, 4'd8);

    set_model(0, 0, 0, 0, 0, 0, 0);
    kick(5'b00000, 2'b00);
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R11 abort mid load", {ctrl_o, busy_o, img_ready_o}, {10'h002, 2'b00});

    summary();
    $finish;
  end

endmodule